// File: doc/BRIEF.md
# Indirect Operand Address Generator

This block is the address front end of a pipelined 8-bit accumulator processor. Each accepted request carries an addressing mode, an opcode literal, and the current X and Y index values. From these the block forms the 16-bit effective address for the data memory. The supported modes are absolute, absolute indexed by X or Y, zero-page pre-indexed indirect (zp,X) and zero-page post-indexed indirect (zp),Y.

The indirect modes need a pointer fetched from the zero page. The block holds the zero-page byte store itself. The store has two independent synchronous byte read ports, which fetch the two pointer bytes in the same cycle, and one byte write port driven by the processor's writeback. A pointer at any alignment, including one whose low byte sits at the last zero-page location, costs no extra cycle.

The work is split across two registered stages, so a new request can enter on every cycle. A stall input freezes both stages together.

Top module: `ind_addr_gen`

## Requirements
- R1: With mode code 0 (absolute), the effective address equals the 16-bit literal.
- R2: With mode code 1 (literal plus X) or code 2 (literal plus Y), the effective address is the 16-bit literal plus the zero-extended index. The carry propagates into the high byte, the sum wraps modulo 65536, and a page crossing adds no cycle.
- R3: With mode code 4, (zp),Y, the low literal byte zp selects a pointer whose low byte is store[zp] and whose high byte is store[(zp+1) mod 256]. The effective address is that pointer plus Y, as a full 16-bit sum.
- R4: With mode code 3, (zp,X), let b = (zp + X) mod 256. The effective address is {store[(b+1) mod 256], store[b]}, with no further addition.
- R5: A request sampled at clock edge k with stall low shows its result on the outputs after edge k+1. Requests can be accepted on consecutive cycles, for any pointer alignment and any mix of modes.
- R6: While stall is high at an edge, the outputs and all pipeline state hold, and the request inputs at that edge are ignored. The in-flight request completes normally once stall falls.
- R7: ea_valid is high after edge k+1 exactly when in_valid was high at an accepted edge k. Cycles without a request produce ea_valid low.
- R8: While rst_n is low, ea_valid and ea_addr are 0.
- R9: A zero-page write at an edge updates the byte for later reads, whatever the state of stall. A pointer read of the same byte at that same edge returns the old value.
- R10: Mode codes 5, 6 and 7 behave as absolute: the effective address equals the literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze both pipeline stages |
| in_valid | input | 1 | A request is present |
| in_mode | input | 3 | Addressing mode code |
| in_lit | input | 16 | Opcode literal (low byte is zp for indirect modes) |
| reg_x | input | 8 | X index value |
| reg_y | input | 8 | Y index value |
| zp_wr_en | input | 1 | Zero-page byte write enable |
| zp_wr_addr | input | 8 | Zero-page write address |
| zp_wr_data | input | 8 | Zero-page write data |
| ea_valid | output | 1 | Effective address is valid |
| ea_addr | output | 16 | Effective address |

## Verification
If the pointer byte addresses are corrupted, for example with no wrap at the top of the zero page or with a wrong pre-index sum, the indirect results show a wrong high or low byte two edges after the request. A broken stage-one register, or a pointer read left enabled during a stall, shows up as a wrong or shifted address on the first output after stall is released. A lost carry in the shared adder shows as a high byte that is off by one only on page-crossing sums. A valid bit that is dropped or duplicated in the pipeline shows on ea_valid in the cycle right after the expected result.

// File: rtl/ind_addr_pkg.sv
package ind_addr_pkg;
   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] AM_ABS   = 3'd0;
   localparam logic [MODE_W-1:0] AM_ABS_X = 3'd1;
   localparam logic [MODE_W-1:0] AM_ABS_Y = 3'd2;
   localparam logic [MODE_W-1:0] AM_IND_X = 3'd3;
   localparam logic [MODE_W-1:0] AM_IND_Y = 3'd4;

   function automatic logic is_indirect(input logic [MODE_W-1:0] m);
      return (m == AM_IND_X) || (m == AM_IND_Y);
   endfunction

   function automatic logic uses_y(input logic [MODE_W-1:0] m);
      return (m == AM_ABS_Y) || (m == AM_IND_Y);
   endfunction
endpackage

// File: rtl/zp_dual_read_ram.sv
module zp_dual_read_ram #(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int NRD         = 2,
   parameter bit WRITE_FIRST = 1'b0
) (
   input  logic                    clk,
   input  logic                    rd_en,
   input  logic [NRD-1:0][AW-1:0]  rd_addr,
   output logic [NRD-1:0][DW-1:0]  rd_data,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [DW-1:0]           wr_data
);
   localparam int DEPTH = 1 << AW;

   if (NRD < 1) begin : g_bad_nrd
      $error("zp_dual_read_ram needs at least one read port");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_port
      if (WRITE_FIRST) begin : g_wf
         always_ff @(posedge clk) begin
            if (rd_en) begin
               if (wr_en && (wr_addr == rd_addr[p])) rd_data[p] <= wr_data;
               else                                  rd_data[p] <= mem[rd_addr[p]];
            end
         end
      end else begin : g_rf
         always_ff @(posedge clk) begin
            if (rd_en) rd_data[p] <= mem[rd_addr[p]];
         end
      end
   end
endmodule

// File: rtl/ind_ptr_stage.sv
module ind_ptr_stage
   import ind_addr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              in_valid,
   input  logic [MODE_W-1:0] in_mode,
   input  logic [ADDR_W-1:0] in_lit,
   input  logic [BYTE_W-1:0] reg_x,
   input  logic [BYTE_W-1:0] reg_y,
   output logic [BYTE_W-1:0] ptr_lo_addr,
   output logic [BYTE_W-1:0] ptr_hi_addr,
   output logic              s1_valid,
   output logic [MODE_W-1:0] s1_mode,
   output logic [ADDR_W-1:0] s1_lit,
   output logic [BYTE_W-1:0] s1_idx
);
   // read path A: X (pre-index and literal+X); read path B: Y
   logic [BYTE_W-1:0] path_a, path_b;
   logic [BYTE_W-1:0] zp_base;
   logic [BYTE_W-1:0] idx_sel;

   assign path_a = reg_x;
   assign path_b = reg_y;

   always_comb begin
      zp_base = in_lit[BYTE_W-1:0];
      if (in_mode == AM_IND_X) zp_base = in_lit[BYTE_W-1:0] + path_a;
   end

   assign ptr_lo_addr = zp_base;
   assign ptr_hi_addr = zp_base + {{(BYTE_W-1){1'b0}}, 1'b1};

   always_comb begin
      idx_sel = '0;
      if (uses_y(in_mode))          idx_sel = path_b;
      else if (in_mode == AM_ABS_X) idx_sel = path_a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mode  <= AM_ABS;
         s1_lit   <= '0;
         s1_idx   <= '0;
      end else if (adv) begin
         s1_valid <= in_valid;
         s1_mode  <= in_mode;
         s1_lit   <= in_lit;
         s1_idx   <= idx_sel;
      end
   end

   assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (s1_valid == $past(in_valid)));

   assert_s1_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(s1_valid) && $stable(s1_lit) && $stable(s1_idx)));
endmodule

// File: rtl/ind_ea_stage.sv
module ind_ea_stage
   import ind_addr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              s1_valid,
   input  logic [MODE_W-1:0] s1_mode,
   input  logic [ADDR_W-1:0] s1_lit,
   input  logic [BYTE_W-1:0] s1_idx,
   input  logic [BYTE_W-1:0] ptr_lo,
   input  logic [BYTE_W-1:0] ptr_hi,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] ea_addr
);
   localparam int PAD_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] pointer;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] ea_next;

   assign pointer = {ptr_hi, ptr_lo};
   assign base    = is_indirect(s1_mode) ? pointer : s1_lit;
   // one 16+8 adder, independent of the ALU
   assign ea_next = base + {{PAD_W{1'b0}}, s1_idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_valid <= 1'b0;
         ea_addr  <= '0;
      end else if (adv) begin
         ea_valid <= s1_valid;
         ea_addr  <= ea_next;
      end
   end

   assert_abs_literal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && s1_valid && (s1_mode == AM_ABS)) |=> (ea_addr == $past(s1_lit)));

   assert_unused_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && s1_valid && (s1_mode > AM_IND_Y)) |=> (ea_addr == $past(s1_lit)));

   assert_preindex_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && s1_valid && (s1_mode == AM_IND_X)) |=> (ea_addr == $past({ptr_hi, ptr_lo})));

   assert_postindex_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && s1_valid && (s1_mode == AM_IND_Y)) |=>
      (ea_addr == $past({ptr_hi, ptr_lo}) + {{PAD_W{1'b0}}, $past(s1_idx)}));
endmodule

// File: rtl/ind_addr_gen.sv
module ind_addr_gen
   import ind_addr_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int BYTE_W      = 8,
   parameter bit WRITE_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              in_valid,
   input  logic [2:0]        in_mode,
   input  logic [ADDR_W-1:0] in_lit,
   input  logic [BYTE_W-1:0] reg_x,
   input  logic [BYTE_W-1:0] reg_y,
   input  logic              zp_wr_en,
   input  logic [BYTE_W-1:0] zp_wr_addr,
   input  logic [BYTE_W-1:0] zp_wr_data,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] ea_addr
);
   localparam int NPORT = 2;

   if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
      $error("ind_addr_gen: ADDR_W must be twice BYTE_W to join a pointer");
   end
   if (MODE_W != 3) begin : g_bad_mode
      $error("ind_addr_gen: mode code width mismatch");
   end

   logic                           adv;
   logic [BYTE_W-1:0]              ptr_lo_addr, ptr_hi_addr;
   logic [NPORT-1:0][BYTE_W-1:0]   rd_addr;
   logic [NPORT-1:0][BYTE_W-1:0]   rd_data;
   logic                           s1_valid;
   logic [MODE_W-1:0]              s1_mode;
   logic [ADDR_W-1:0]              s1_lit;
   logic [BYTE_W-1:0]              s1_idx;

   assign adv        = !stall;
   assign rd_addr[0] = ptr_lo_addr;
   assign rd_addr[1] = ptr_hi_addr;

   ind_ptr_stage #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_s1 (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_valid(in_valid), .in_mode(in_mode), .in_lit(in_lit),
      .reg_x(reg_x), .reg_y(reg_y),
      .ptr_lo_addr(ptr_lo_addr), .ptr_hi_addr(ptr_hi_addr),
      .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_lit(s1_lit), .s1_idx(s1_idx)
   );

   zp_dual_read_ram #(.AW(BYTE_W), .DW(BYTE_W), .NRD(NPORT), .WRITE_FIRST(WRITE_FIRST)) u_zp (
      .clk(clk), .rd_en(adv), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(zp_wr_en), .wr_addr(zp_wr_addr), .wr_data(zp_wr_data)
   );

   ind_ea_stage #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_s2 (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_lit(s1_lit), .s1_idx(s1_idx),
      .ptr_lo(rd_data[0]), .ptr_hi(rd_data[1]),
      .ea_valid(ea_valid), .ea_addr(ea_addr)
   );

   assert_stall_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(ea_addr) && $stable(ea_valid)));

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |-> (!ea_valid && (ea_addr == '0)));
endmodule

// File: tb/sim_ind_addr_gen.sv
module sim_ind_addr_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_mode = 3'd0;
   logic [15:0] in_lit = 16'h0;
   logic [7:0]  reg_x = 8'h0;
   logic [7:0]  reg_y = 8'h0;
   logic        zp_wr_en = 1'b0;
   logic [7:0]  zp_wr_addr = 8'h0;
   logic [7:0]  zp_wr_data = 8'h0;
   logic        ea_valid;
   logic [15:0] ea_addr;

   int checks = 0;
   int errors = 0;
   logic [7:0] zmem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   ind_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid),
      .in_mode(in_mode), .in_lit(in_lit), .reg_x(reg_x), .reg_y(reg_y),
      .zp_wr_en(zp_wr_en), .zp_wr_addr(zp_wr_addr), .zp_wr_data(zp_wr_data),
      .ea_valid(ea_valid), .ea_addr(ea_addr)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_ind_y(input logic [7:0] zp, input logic [7:0] y);
      logic [7:0] hi_a;
      hi_a = zp + 8'd1;
      return {zmem[hi_a], zmem[zp]} + {8'h00, y};
   endfunction

   function automatic logic [15:0] exp_ind_x(input logic [7:0] zp, input logic [7:0] x);
      logic [7:0] b, b1;
      b  = zp + x;
      b1 = b + 8'd1;
      return {zmem[b1], zmem[b]};
   endfunction

   task automatic drive(input logic [2:0] m, input logic [15:0] lit,
                        input logic [7:0] x, input logic [7:0] y);
      in_valid = 1'b1; in_mode = m; in_lit = lit; reg_x = x; reg_y = y;
   endtask

   // one request, result checked two edges later
   task automatic single(input string tag, input logic [2:0] m, input logic [15:0] lit,
                         input logic [7:0] x, input logic [7:0] y, input logic [15:0] exp);
      @(negedge clk); drive(m, lit, x, y);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      chk({tag, " valid"}, {15'd0, ea_valid}, 16'd1);
      chk({tag, " addr"}, ea_addr, exp);
   endtask

   task automatic load_zero_page();
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         zp_wr_en = 1'b1; zp_wr_addr = 8'(i); zp_wr_data = 8'(i * 73 + 29);
         zmem[i] = 8'(i * 73 + 29);
      end
      @(negedge clk); zp_wr_en = 1'b0;
   endtask

   task automatic test_reset();
      chk("R8 reset valid", {15'd0, ea_valid}, 16'd0);
      chk("R8 reset addr", ea_addr, 16'h0000);
   endtask

   task automatic test_absolute();
      single("R1 absolute", 3'd0, 16'hBEEF, 8'h11, 8'h22, 16'hBEEF);
      single("R10 code 6 as absolute", 3'd6, 16'h4321, 8'h11, 8'h22, 16'h4321);
      single("R10 code 7 as absolute", 3'd7, 16'h0F0F, 8'hFF, 8'hFF, 16'h0F0F);
   endtask

   task automatic test_indexed();
      single("R2 lit+X carry", 3'd1, 16'h12F0, 8'h25, 8'h00, 16'h1315);
      single("R2 lit+Y wrap", 3'd2, 16'hFFF0, 8'h77, 8'h20, 16'h0010);
      single("R2 lit+Y no carry", 3'd2, 16'h2000, 8'h99, 8'h05, 16'h2005);
   endtask

   task automatic test_post_indexed();
      single("R3 (zp),Y mid", 3'd4, 16'h0040, 8'h00, 8'h03, exp_ind_y(8'h40, 8'h03));
      single("R3 (zp),Y carry", 3'd4, 16'h0013, 8'h00, 8'hFF, exp_ind_y(8'h13, 8'hFF));
      single("R3 R5 (zp),Y last byte", 3'd4, 16'h00FF, 8'h00, 8'h01, exp_ind_y(8'hFF, 8'h01));
   endtask

   task automatic test_pre_indexed();
      single("R4 (zp,X) mid", 3'd3, 16'h0010, 8'h05, 8'hEE, exp_ind_x(8'h10, 8'h05));
      single("R4 R5 (zp,X) at last byte", 3'd3, 16'h00F0, 8'h0F, 8'h00, exp_ind_x(8'hF0, 8'h0F));
      single("R4 (zp,X) sum wraps", 3'd3, 16'h0080, 8'h90, 8'h00, exp_ind_x(8'h80, 8'h90));
   endtask

   task automatic test_stream();
      logic [2:0]  m [4] = '{3'd4, 3'd3, 3'd1, 3'd4};
      logic [15:0] l [4] = '{16'h00FF, 16'h0007, 16'h30FF, 16'h0021};
      logic [7:0]  x [4] = '{8'h00, 8'hF8, 8'h01, 8'h00};
      logic [7:0]  y [4] = '{8'h10, 8'h00, 8'h00, 8'h80};
      logic [15:0] e [4];
      e[0] = exp_ind_y(8'hFF, 8'h10);
      e[1] = exp_ind_x(8'h07, 8'hF8);
      e[2] = 16'h3100;
      e[3] = exp_ind_y(8'h21, 8'h80);
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         if (i >= 2 && i < 6) begin
            chk($sformatf("R5 R7 stream %0d valid", i-2), {15'd0, ea_valid}, 16'd1);
            chk($sformatf("R5 stream %0d addr", i-2), ea_addr, e[i-2]);
         end
         if (i == 6) chk("R7 stream tail idle", {15'd0, ea_valid}, 16'd0);
         if (i < 4) drive(m[i], l[i], x[i], y[i]);
         else       in_valid = 1'b0;
      end
   endtask

   task automatic test_stall();
      logic [15:0] snap_a;
      logic        snap_v;
      logic [15:0] exp_a;
      exp_a = exp_ind_y(8'h55, 8'h44);
      @(negedge clk); drive(3'd4, 16'h0055, 8'h00, 8'h44);
      @(negedge clk);
      snap_a = ea_addr; snap_v = ea_valid;
      stall = 1'b1; drive(3'd0, 16'hDEAD, 8'h00, 8'h00);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R6 stall holds addr", ea_addr, snap_a);
         chk("R6 stall holds valid", {15'd0, ea_valid}, {15'd0, snap_v});
      end
      stall = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      chk("R6 in-flight after stall valid", {15'd0, ea_valid}, 16'd1);
      chk("R6 in-flight after stall addr", ea_addr, exp_a);
      @(negedge clk);
      chk("R6 R7 stalled input ignored", {15'd0, ea_valid}, 16'd0);
   endtask

   task automatic test_write_collision();
      logic [15:0] old_e;
      old_e = exp_ind_y(8'h60, 8'h00);
      @(negedge clk);
      drive(3'd4, 16'h0060, 8'h00, 8'h00);
      zp_wr_en = 1'b1; zp_wr_addr = 8'h60; zp_wr_data = 8'hA5;
      @(negedge clk);
      in_valid = 1'b0; zp_wr_en = 1'b0;
      zmem[8'h60] = 8'hA5;
      @(negedge clk);
      chk("R9 same-edge read sees old byte", ea_addr, old_e);
      single("R9 later read sees new byte", 3'd4, 16'h0060, 8'h00, 8'h00, exp_ind_y(8'h60, 8'h00));
      // write during stall still lands
      @(negedge clk);
      stall = 1'b1; zp_wr_en = 1'b1; zp_wr_addr = 8'h61; zp_wr_data = 8'h3C;
      @(negedge clk);
      stall = 1'b0; zp_wr_en = 1'b0;
      zmem[8'h61] = 8'h3C;
      single("R9 write during stall", 3'd4, 16'h0060, 8'h00, 8'h02, exp_ind_y(8'h60, 8'h02));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 idle after reset", {15'd0, ea_valid}, 16'd0);
      load_zero_page();
      test_absolute();
      test_indexed();
      test_post_indexed();
      test_pre_indexed();
      test_stream();
      test_stall();
      test_write_collision();
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule